// File: doc/BRIEF.md
# Bufferless Deflection Routing Node

This block is one switching point of a two-dimensional torus network. Every cycle each of its four network links may deliver one complete packet. A local endpoint, such as a processor or memory, may also offer one packet. The node works out which links bring each packet closer to its destination. It then hands out the output links one packet at a time, in order of a priority drawn at random for that packet on arrival.

The node has no queue and never stalls. Every packet it accepts leaves two clock edges later. A packet that loses its productive links to higher-priority packets is sent out on whatever network link is still free. A packet addressed to this node leaves on the local eject port. The endpoint may inject only when at least one network input is idle, so that a network output is certain to be free for the new packet. Because priorities are reshuffled at every hop, no input lane keeps losing, and misrouted packets keep moving until they arrive.

Top module: `defl_node`

## Requirements
- R1: After reset all outputs show no valid packet. With no network input valid, `inj_ready` is high whenever the local port is present (HAS_LOCAL=1).
- R2: A packet accepted at clock edge t leaves, with all bits unchanged, right after edge t+1, which is two register stages later.
- R3: The number of valid packets leaving (network outputs plus eject) equals the number accepted one edge earlier. Each accepted packet appears exactly once.
- R4: Header layout and routing rule: the destination x is bits [COORD_W-1:0] and y is bits [2*COORD_W-1:COORD_W]. Each ring holds 2^COORD_W nodes, and ports are numbered 0=+x, 1=-x, 2=+y, 3=-y. For d=(dst-own) mod 2^COORD_W in a dimension: 0<d<half makes the plus port productive, d>half makes the minus port productive, and d=half makes both productive. A packet alone in the node leaves on a productive port.
- R5: A packet leaves on a non-productive network port only if, in that same cycle, every one of its productive ports carries some other packet.
- R6: A packet whose destination equals the node's own coordinates is productive only toward the eject port. At most one such packet is ejected per cycle. Any other is deflected to the network, and only while the eject port is busy. Every ejected packet is addressed to this node.
- R7: `inj_ready` is high exactly when HAS_LOCAL=1 and fewer than four network inputs are valid in the same cycle. An injected packet is accepted only when `inj_valid` and `inj_ready` are both high.
- R8: Priorities come from a free-running linear feedback shift register that never reaches zero, with ties going to the lower lane. Under steady full contention for one port, every input lane wins that port at least once within 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | COORD_W | Own x coordinate, held static while traffic flows |
| node_y | input | COORD_W | Own y coordinate, held static while traffic flows |
| in_valid | input | 4 | Per network input link: packet present |
| in_pkt | input | 4 x PKT_W | Packets on the network input links |
| out_valid | output | 4 | Per network output link: packet present |
| out_pkt | output | 4 x PKT_W | Packets on the network output links |
| inj_valid | input | 1 | Local endpoint offers a packet |
| inj_pkt | input | PKT_W | Packet offered by the local endpoint |
| inj_ready | output | 1 | Offered packet is taken this cycle |
| ej_valid | output | 1 | Packet delivered to the local endpoint |
| ej_pkt | output | PKT_W | Packet delivered to the local endpoint |

## Verification
Single packets sent toward each neighbour, and to the exact half-ring distance, separate a correct distance rule from a sign error or a missed tie. Four packets that all want the same link, and several packets addressed to the node itself, show whether losers are deflected rather than dropped or duplicated. They also show whether the eject port is shared correctly. Full and nearly full network inputs, with injection offered, probe the admission gate. Long random traffic with random destinations and injection checks packet conservation and the deflection rule over many mixes. A steady contention run shows that the random priorities rotate the winner among the lanes.

// File: rtl/defl_pkg.sv
`timescale 1ns/1ps
package defl_pkg;
    localparam int NET_PORTS = 4;
    localparam int ALL_PORTS = NET_PORTS + 1;

    typedef enum logic [2:0] {
        DIR_XP  = 3'd0,
        DIR_XN  = 3'd1,
        DIR_YP  = 3'd2,
        DIR_YN  = 3'd3,
        DIR_LOC = 3'd4
    } dir_e;
endpackage

// File: rtl/defl_lfsr.sv
`timescale 1ns/1ps
module defl_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'hE000_0200,
    parameter logic [W-1:0] SEED = 32'h0000_0001
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Galois form, right shift; the top tap bit keeps the state nonzero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (state[0]) begin
            state <= (state >> 1) ^ TAPS;
        end else begin
            state <= state >> 1;
        end
    end
endmodule

// File: rtl/defl_route.sv
`timescale 1ns/1ps
module defl_route import defl_pkg::*; #(
    parameter int COORD_W   = 2,
    parameter int HAS_LOCAL = 1
) (
    input  logic [COORD_W-1:0]   cur_x,
    input  logic [COORD_W-1:0]   cur_y,
    input  logic [COORD_W-1:0]   dst_x,
    input  logic [COORD_W-1:0]   dst_y,
    output logic [ALL_PORTS-1:0] prod
);
    localparam logic [COORD_W-1:0] HALF = COORD_W'(1 << (COORD_W - 1));

    logic [COORD_W-1:0] dx, dy;

    always_comb begin
        dx   = dst_x - cur_x;
        dy   = dst_y - cur_y;
        prod = '0;
        if (dx != '0) begin
            if (dx <= HALF) prod[DIR_XP] = 1'b1;
            if (dx >= HALF) prod[DIR_XN] = 1'b1;
        end
        if (dy != '0) begin
            if (dy <= HALF) prod[DIR_YP] = 1'b1;
            if (dy >= HALF) prod[DIR_YN] = 1'b1;
        end
        prod[DIR_LOC] = (HAS_LOCAL != 0) && (dx == '0) && (dy == '0);
    end
endmodule

// File: rtl/defl_alloc.sv
`timescale 1ns/1ps
module defl_alloc #(
    parameter int NIN    = 5,
    parameter int NOUT   = 5,
    parameter int NNET   = 4,
    parameter int PRIO_W = 8,
    localparam int SRC_W = $clog2(NIN)
) (
    input  logic [NIN-1:0]                 in_vld,
    input  logic [NIN-1:0][PRIO_W-1:0]     prio,
    input  logic [NIN-1:0][NOUT-1:0]       prod,
    output logic [NOUT-1:0]                out_vld,
    output logic [NOUT-1:0][SRC_W-1:0]     out_src
);
    int rank [NIN];

    // rank = number of valid lanes that beat this one (higher prio, or equal prio and lower index)
    always_comb begin
        for (int i = 0; i < NIN; i++) begin
            rank[i] = 0;
            for (int j = 0; j < NIN; j++) begin
                if (j != i && in_vld[j] &&
                    (prio[j] > prio[i] || (prio[j] == prio[i] && j < i))) begin
                    rank[i] = rank[i] + 1;
                end
            end
        end
    end

    // serve lanes best first: a free productive port, else any free network port
    always_comb begin
        logic [NOUT-1:0] taken;
        logic            done;
        taken   = '0;
        done    = 1'b0;
        out_vld = '0;
        out_src = '0;
        for (int r = 0; r < NIN; r++) begin
            for (int i = 0; i < NIN; i++) begin
                if (in_vld[i] && rank[i] == r) begin
                    done = 1'b0;
                    for (int o = 0; o < NOUT; o++) begin
                        if (!done && prod[i][o] && !taken[o]) begin
                            taken[o]   = 1'b1;
                            out_vld[o] = 1'b1;
                            out_src[o] = SRC_W'(i);
                            done       = 1'b1;
                        end
                    end
                    for (int o = 0; o < NNET; o++) begin
                        if (!done && !taken[o]) begin
                            taken[o]   = 1'b1;
                            out_vld[o] = 1'b1;
                            out_src[o] = SRC_W'(i);
                            done       = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/defl_node.sv
`timescale 1ns/1ps
module defl_node import defl_pkg::*; #(
    parameter int               COORD_W   = 2,
    parameter int               PKT_W     = 164,
    parameter int               PRIO_W    = 8,
    parameter int               LFSR_W    = 32,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'hE000_0200,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h0000_0001,
    parameter int               HAS_LOCAL = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [COORD_W-1:0]              node_x,
    input  logic [COORD_W-1:0]              node_y,
    input  logic [NET_PORTS-1:0]            in_valid,
    input  logic [NET_PORTS-1:0][PKT_W-1:0] in_pkt,
    output logic [NET_PORTS-1:0]            out_valid,
    output logic [NET_PORTS-1:0][PKT_W-1:0] out_pkt,
    input  logic                            inj_valid,
    input  logic [PKT_W-1:0]                inj_pkt,
    output logic                            inj_ready,
    output logic                            ej_valid,
    output logic [PKT_W-1:0]                ej_pkt
);
    localparam int NIN       = ALL_PORTS;
    localparam int SRC_W     = $clog2(NIN);
    localparam int PRIO_STEP = (LFSR_W - PRIO_W) / (NIN - 1);

    logic [LFSR_W-1:0]               lfsr_state;
    logic [NIN-1:0]                  s1_valid;
    logic [NIN-1:0][PKT_W-1:0]       s1_pkt;
    logic [NIN-1:0][PRIO_W-1:0]      s1_prio;
    logic [NIN-1:0][ALL_PORTS-1:0]   s1_prod;
    logic [ALL_PORTS-1:0]            alloc_vld;
    logic [ALL_PORTS-1:0][SRC_W-1:0] alloc_src;

    // a network output is certain to be free only if some network input is idle
    assign inj_ready = (HAS_LOCAL != 0) && !(&in_valid);

    defl_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_state)
    );

    // stage 1: capture lanes and draw one priority per lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= '0;
            s1_pkt   <= '0;
            s1_prio  <= '0;
        end else begin
            for (int i = 0; i < NET_PORTS; i++) begin
                s1_valid[i] <= in_valid[i];
                s1_pkt[i]   <= in_pkt[i];
            end
            s1_valid[DIR_LOC] <= inj_valid && inj_ready;
            s1_pkt[DIR_LOC]   <= inj_pkt;
            for (int i = 0; i < NIN; i++) begin
                s1_prio[i] <= lfsr_state[i*PRIO_STEP +: PRIO_W];
            end
        end
    end

    for (genvar g = 0; g < NIN; g++) begin : g_route
        defl_route #(.COORD_W(COORD_W), .HAS_LOCAL(HAS_LOCAL)) u_route (
            .cur_x (node_x),
            .cur_y (node_y),
            .dst_x (s1_pkt[g][COORD_W-1:0]),
            .dst_y (s1_pkt[g][2*COORD_W-1:COORD_W]),
            .prod  (s1_prod[g])
        );
    end

    defl_alloc #(.NIN(NIN), .NOUT(ALL_PORTS), .NNET(NET_PORTS), .PRIO_W(PRIO_W)) u_alloc (
        .in_vld  (s1_valid),
        .prio    (s1_prio),
        .prod    (s1_prod),
        .out_vld (alloc_vld),
        .out_src (alloc_src)
    );

    // stage 2: output registers drive the links
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_pkt   <= '0;
            ej_valid  <= 1'b0;
            ej_pkt    <= '0;
        end else begin
            for (int o = 0; o < NET_PORTS; o++) begin
                out_valid[o] <= alloc_vld[o];
                out_pkt[o]   <= s1_pkt[alloc_src[o]];
            end
            ej_valid <= alloc_vld[DIR_LOC];
            ej_pkt   <= s1_pkt[alloc_src[DIR_LOC]];
        end
    end
endmodule

// File: rtl/defl_node_chk.sv
`timescale 1ns/1ps
module defl_node_chk import defl_pkg::*; #(
    parameter int COORD_W   = 2,
    parameter int PKT_W     = 164,
    parameter int LFSR_W    = 32,
    parameter int HAS_LOCAL = 1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [COORD_W-1:0]              node_x,
    input logic [COORD_W-1:0]              node_y,
    input logic [NET_PORTS-1:0]            in_valid,
    input logic                            inj_valid,
    input logic                            inj_ready,
    input logic [NET_PORTS-1:0]            out_valid,
    input logic [NET_PORTS-1:0][PKT_W-1:0] out_pkt,
    input logic                            ej_valid,
    input logic [PKT_W-1:0]                ej_pkt,
    input logic [ALL_PORTS-1:0]            s1_valid,
    input logic [LFSR_W-1:0]               lfsr_state
);
    logic started;
    logic local_on_net;

    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    always_comb begin
        local_on_net = 1'b0;
        for (int o = 0; o < NET_PORTS; o++) begin
            if (out_valid[o] && out_pkt[o][COORD_W-1:0] == node_x &&
                out_pkt[o][2*COORD_W-1:COORD_W] == node_y) begin
                local_on_net = 1'b1;
            end
        end
    end

    AST_LANE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> $countones(s1_valid) ==
                    $past($countones(in_valid) + ((inj_valid && inj_ready) ? 1 : 0))); // R3
    AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> ($countones(out_valid) + (ej_valid ? 1 : 0)) == $past($countones(s1_valid))); // R3
    AST_EJECT_HERE: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid |-> (ej_pkt[COORD_W-1:0] == node_x && ej_pkt[2*COORD_W-1:COORD_W] == node_y)); // R6
    AST_LOCAL_DEFLECT: assert property (@(posedge clk) disable iff (!rst_n)
        (local_on_net && HAS_LOCAL != 0) |-> ej_valid); // R6
    AST_INJ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (&in_valid) |-> !inj_ready); // R7
    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> lfsr_state != '0); // R8
endmodule

bind defl_node defl_node_chk #(
    .COORD_W   (COORD_W),
    .PKT_W     (PKT_W),
    .LFSR_W    (LFSR_W),
    .HAS_LOCAL (HAS_LOCAL)
) i_chk (.*);

// File: tb/test_defl_node.sv
`timescale 1ns/1ps
module test_defl_node;
    localparam int CW = 2;
    localparam int PW = 164;
    localparam int NP = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [CW-1:0]         node_x = '0, node_y = '0;
    logic [NP-1:0]         in_valid = '0;
    logic [NP-1:0][PW-1:0] in_pkt = '0;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0][PW-1:0] out_pkt;
    logic                  inj_valid = 1'b0;
    logic [PW-1:0]         inj_pkt = '0;
    logic                  inj_ready;
    logic                  ej_valid;
    logic [PW-1:0]         ej_pkt;

    int checks = 0;
    int errors = 0;
    int serial = 1;
    bit done_flag = 1'b0;
    bit track_wins = 1'b0;
    int wins [NP];
    logic          hist_v [5];
    logic [PW-1:0] hist_p [5];

    always #10 clk = ~clk;

    defl_node i_defl_node (
        .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
        .in_valid(in_valid), .in_pkt(in_pkt), .out_valid(out_valid), .out_pkt(out_pkt),
        .inj_valid(inj_valid), .inj_pkt(inj_pkt), .inj_ready(inj_ready),
        .ej_valid(ej_valid), .ej_pkt(ej_pkt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bench copy of the routing rule stated in R4/R6
    function automatic logic [4:0] prod_mask(input logic [PW-1:0] p);
        logic [CW-1:0] dx, dy;
        logic [4:0] m;
        dx = p[CW-1:0] - node_x;
        dy = p[2*CW-1:CW] - node_y;
        m = '0;
        if (dx != 0 && dx < 2) m[0] = 1'b1;
        if (dx > 2) m[1] = 1'b1;
        if (dx == 2) m[1:0] = 2'b11;
        if (dy != 0 && dy < 2) m[2] = 1'b1;
        if (dy > 2) m[3] = 1'b1;
        if (dy == 2) m[3:2] = 2'b11;
        if (dx == 0 && dy == 0) m[4] = 1'b1;
        return m;
    endfunction

    // top 8 bits: lane tag, next 32: serial, low 2*CW: destination
    function automatic logic [PW-1:0] mkpkt(input int lane, input logic [CW-1:0] dx,
                                            input logic [CW-1:0] dy);
        logic [191:0] r;
        logic [PW-1:0] p;
        r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        p = r[PW-1:0];
        p[PW-1 -: 8]  = 8'(lane);
        p[PW-9 -: 32] = 32'(serial);
        serial++;
        p[CW-1:0]    = dx;
        p[2*CW-1:CW] = dy;
        return p;
    endfunction

    task automatic check_outputs();
        bit used [5];
        int nexp, nout, lone;
        nexp = 0;
        for (int j = 0; j < 5; j++) begin
            used[j] = 1'b0;
            if (hist_v[j]) nexp++;
        end
        nout = $countones(out_valid) + (ej_valid ? 1 : 0);
        chk(nout == nexp, "R3 packet count", nout, nexp);
        lone = (nexp == 1);
        for (int o = 0; o < 5; o++) begin
            logic ov;
            logic [PW-1:0] op;
            logic [4:0] pm;
            bit found;
            ov = (o < 4) ? out_valid[o] : ej_valid;
            op = (o < 4) ? out_pkt[o] : ej_pkt;
            if (ov) begin
                found = 1'b0;
                for (int j = 0; j < 5; j++) begin
                    if (!found && hist_v[j] && !used[j] && hist_p[j] == op) begin
                        used[j] = 1'b1;
                        found = 1'b1;
                    end
                end
                chk(found, "R2 packet appears unchanged two edges later", found, 1);
                pm = prod_mask(op);
                if (o == 4) begin
                    chk(pm[4], "R6 ejected packet addressed here", pm[4], 1);
                end else if (!pm[o]) begin
                    for (int q = 0; q < 5; q++) begin
                        if (pm[q]) begin
                            logic occ;
                            occ = (q < 4) ? out_valid[q] : ej_valid;
                            chk(occ, (q < 4) ? "R5 deflected while productive port free"
                                             : "R6 local packet deflected while eject idle",
                                occ, 1);
                        end
                    end
                end
                if (lone && o < 4 && pm[3:0] != 0)
                    chk(pm[o], "R4 lone packet on productive port", o, pm);
                if (track_wins && o == 0) wins[op[PW-1 -: 8] % NP]++;
            end
        end
    endtask

    // drive at a falling edge, check the R7 gate, then advance one cycle and check outputs
    task automatic cycle(input logic [NP-1:0] v, input logic [NP-1:0][PW-1:0] p,
                         input logic iv, input logic [PW-1:0] ip);
        logic          nv [5];
        logic [PW-1:0] np [5];
        in_valid = v; in_pkt = p; inj_valid = iv; inj_pkt = ip;
        #1;
        chk(inj_ready == !(&v), "R7 inject gate", inj_ready, !(&v));
        for (int i = 0; i < NP; i++) begin
            nv[i] = v[i];
            np[i] = p[i];
        end
        nv[4] = iv && inj_ready;
        np[4] = ip;
        @(posedge clk);
        @(negedge clk);
        check_outputs();
        for (int j = 0; j < 5; j++) begin
            hist_v[j] = nv[j];
            hist_p[j] = np[j];
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cycle('0, '0, 1'b0, '0);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [NP-1:0][PW-1:0] pk;
        void'($urandom(32'd4242));
        for (int j = 0; j < 5; j++) begin
            hist_v[j] = 1'b0;
            hist_p[j] = '0;
        end
        for (int i = 0; i < NP; i++) wins[i] = 0;
        node_x = 2'd1; node_y = 2'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        chk(ej_valid == 0, "R1 ej_valid after reset", ej_valid, 0);
        chk(inj_ready == 1, "R1 inj_ready idle", inj_ready, 1);

        // R4: one packet toward each neighbour, and the half-ring tie
        pk = '0; pk[0] = mkpkt(0, node_x + 2'd1, node_y); cycle(4'b0001, pk, 1'b0, '0);
        pk = '0; pk[1] = mkpkt(1, node_x - 2'd1, node_y); cycle(4'b0010, pk, 1'b0, '0);
        pk = '0; pk[2] = mkpkt(2, node_x, node_y + 2'd1); cycle(4'b0100, pk, 1'b0, '0);
        pk = '0; pk[3] = mkpkt(3, node_x, node_y - 2'd1); cycle(4'b1000, pk, 1'b0, '0);
        pk = '0; pk[0] = mkpkt(0, node_x + 2'd2, node_y); cycle(4'b0001, pk, 1'b0, '0);
        pk = '0; pk[3] = mkpkt(3, node_x, node_y + 2'd2); cycle(4'b1000, pk, 1'b0, '0);
        idle(1);
        // R6: local delivery, single then contended
        pk = '0; pk[2] = mkpkt(2, node_x, node_y); cycle(4'b0100, pk, 1'b0, '0);
        idle(1);
        chk(hist_v[4] == 0, "R6 idle after eject", hist_v[4], 0);
        for (int i = 0; i < NP; i++) pk[i] = mkpkt(i, node_x, node_y);
        cycle(4'b1111, pk, 1'b0, '0);
        pk[0] = mkpkt(0, node_x, node_y); pk[1] = mkpkt(1, node_x, node_y);
        pk[2] = mkpkt(2, node_x + 2'd1, node_y); pk[3] = mkpkt(3, node_x, node_y - 2'd1);
        cycle(4'b1111, pk, 1'b0, '0);
        // R5: four packets all wanting +x
        for (int i = 0; i < NP; i++) pk[i] = mkpkt(i, node_x + 2'd1, node_y);
        cycle(4'b1111, pk, 1'b0, '0);
        // R7: injection refused when all four busy, taken when three busy
        for (int i = 0; i < NP; i++) pk[i] = mkpkt(i, node_x + 2'd1, node_y);
        cycle(4'b1111, pk, 1'b1, mkpkt(4, node_x - 2'd1, node_y));
        cycle(4'b0111, pk, 1'b1, mkpkt(4, node_x + 2'd1, node_y));
        cycle(4'b0000, pk, 1'b1, mkpkt(4, node_x, node_y));
        idle(2);

        // R8: steady contention for +x rotates the winner
        track_wins = 1'b1;
        for (int k = 0; k < 64; k++) begin
            for (int i = 0; i < NP; i++) pk[i] = mkpkt(i, node_x + 2'd1, node_y);
            cycle(4'b1111, pk, 1'b0, '0);
        end
        idle(1);
        track_wins = 1'b0;
        for (int i = 0; i < NP; i++)
            chk(wins[i] > 0, "R8 lane wins contended port", wins[i], 1);

        // random traffic at a second node position
        node_x = 2'd3; node_y = 2'd0;
        idle(1);
        for (int k = 0; k < 3000; k++) begin
            logic [NP-1:0] v;
            for (int i = 0; i < NP; i++) begin
                v[i]  = ($urandom % 4) != 0;
                pk[i] = mkpkt(i, CW'($urandom), CW'($urandom));
            end
            cycle(v, pk, ($urandom % 2) == 1, mkpkt(4, CW'($urandom), CW'($urandom)));
        end
        idle(2);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule